// File: doc/BRIEF.md
# Bit Field Clear Execution Unit

This unit executes a "clear a bit field" operation inside a processor datapath. It receives a 32-bit operand and an instruction word, decodes where the field starts and where it ends, and returns the operand with that contiguous field forced to zero. Every bit outside the field passes through unchanged. Two instruction layouts are supported, and a format select input picks between them. In the split layout the low index is assembled from two separate immediate pieces.

The top of the field is encoded as an absolute bit index, equal to low + width - 1, and not as a width. When the condition has passed, the unit checks the operand for two illegal cases. A destination index of 15 is illegal, and so is a top index below the low index. In either case the unit raises an "unpredictable" flag and does not write back. A single registered stage gives a fixed one-cycle latency. The timing does not depend on the operand data, the field bounds or the condition.

Top module: `bfc_unit`

## Requirements
- R1: For a legal operation, result bits from the low index to the high index inclusive are 0, and every other result bit equals the operand bit. No result bit is ever 1 where the operand bit is 0.
- R2: With `fmt_i`=0, the high index is `insn_i[20:16]`, the destination is `insn_i[15:12]` and the low index is `insn_i[11:7]`.
- R3: With `fmt_i`=1, the high index is `insn_i[4:0]` and the destination is `insn_i[11:8]`. The low index is {`insn_i[14:12]`, `insn_i[7:6]`}, with the 3-bit piece as the upper bits.
- R4: If the condition passed and the high index is below the low index, then `unpred_o`=1 and `wr_en_o`=0.
- R5: If the condition passed and the destination index is 15, then `unpred_o`=1 and `wr_en_o`=0.
- R6: If `cond_pass_i`=0, then `wr_en_o`=0 and `unpred_o`=0, even when the operand is illegal.
- R7: `valid_o` follows `valid_i` exactly one clock later for every input. Result, destination and flags belong to the operation captured in that cycle, including back-to-back operations.
- R8: While `rst_ni` is low, `valid_o`, `wr_en_o` and `unpred_o` are 0.
- R9: `wr_en_o` and `unpred_o` are never both 1, and neither is 1 without `valid_o`.
- R10: Boundary fields work. Low 0 with high 31 clears the whole word, and low equal to high clears exactly one bit, including bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| fmt_i | input | 1 | Layout select: 0 wide, 1 split |
| insn_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition check passed |
| src_i | input | 32 | Operand register value |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Operand with field cleared |
| rd_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Write back the result |
| unpred_o | output | 1 | Illegal operand, write suppressed |

## Verification
The two illegal-operand checks can fire in the same cycle, and either of them can meet a failed condition. The bench provokes this with an operation that has destination 15 and an inverted field, and expects a single raised flag with no write. The same operation is repeated with the condition false, and then neither output may rise, so condition gating has to win over operand checking. Back-to-back legal and illegal operations check that flags never leak from one cycle into the next.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = $clog2(XLEN);
  localparam int REG_W = 4;

  typedef enum logic {
    FMT_WIDE  = 1'b0,
    FMT_SPLIT = 1'b1
  } fmt_e;

  typedef struct packed {
    logic [IDX_W-1:0] hi;
    logic [IDX_W-1:0] lo;
    logic [REG_W-1:0] rd;
  } field_t;
endpackage

// File: rtl/bfc_decode.sv
module bfc_decode
  import bfc_pkg::*;
(
  input  logic        fmt_i,
  input  logic [31:0] insn_i,
  output field_t      fld_o
);
  always_comb begin
    if (fmt_e'(fmt_i) == FMT_SPLIT) begin
      fld_o.hi = insn_i[4:0];
      fld_o.rd = insn_i[11:8];
      fld_o.lo = {insn_i[14:12], insn_i[7:6]}; // split immediate
    end else begin
      fld_o.hi = insn_i[20:16];
      fld_o.rd = insn_i[15:12];
      fld_o.lo = insn_i[11:7];
    end
  end
endmodule

// File: rtl/bfc_mask.sv
module bfc_mask #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  lo_i,
  input  logic [IDX_W-1:0]  hi_i,
  output logic [DATA_W-1:0] mask_o
);
  // one comparator pair per bit: constant depth, data independent
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(b);
    assign mask_o[b] = (POS >= lo_i) && (POS <= hi_i);
  end
endmodule

// File: rtl/bfc_legal.sv
module bfc_legal
  import bfc_pkg::*;
#(
  parameter logic [REG_W-1:0] BAD_RD = '1
) (
  input  field_t fld_i,
  output logic   illegal_o
);
  assign illegal_o = (fld_i.rd == BAD_RD) || (fld_i.hi < fld_i.lo);
endmodule

// File: rtl/bfc_unit.sv
module bfc_unit
  import bfc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              fmt_i,
  input  logic [31:0]       insn_i,
  input  logic              cond_pass_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [REG_W-1:0]  rd_o,
  output logic              wr_en_o,
  output logic              unpred_o
);
  field_t            fld;
  logic [DATA_W-1:0] mask;
  logic              illegal;

  bfc_decode u_dec (.fmt_i(fmt_i), .insn_i(insn_i), .fld_o(fld));

  bfc_mask #(.DATA_W(DATA_W)) u_mask (.lo_i(fld.lo), .hi_i(fld.hi), .mask_o(mask));

  bfc_legal u_legal (.fld_i(fld), .illegal_o(illegal));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      unpred_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      wr_en_o  <= valid_i && cond_pass_i && !illegal;
      unpred_o <= valid_i && cond_pass_i && illegal;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      rd_o     <= '0;
    end else if (valid_i) begin
      result_o <= src_i & ~mask;
      rd_o     <= fld.rd;
    end
  end
endmodule

// File: rtl/bfc_unit_chk.sv
module bfc_unit_chk
  import bfc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              fmt_i,
  input logic [31:0]       insn_i,
  input logic              cond_pass_i,
  input logic [DATA_W-1:0] src_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [REG_W-1:0]  rd_o,
  input logic              wr_en_o,
  input logic              unpred_o
);
  logic [REG_W-1:0] rd_in;
  assign rd_in = fmt_i ? insn_i[11:8] : insn_i[15:12];

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && unpred_o));
  p_qual_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || unpred_o) |-> valid_o);
  p_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass_i) |=> (!wr_en_o && !unpred_o));
  p_rd15_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_i && rd_in == 4'hF) |=> (unpred_o && !wr_en_o));
  p_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((result_o & ~$past(src_i)) == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r8: assert (!valid_o && !wr_en_o && !unpred_o);
    end
  end
endmodule

bind bfc_unit bfc_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bfc_unit_test.sv
module bfc_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        fmt_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] src_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  rd_o;
  logic        wr_en_o;
  logic        unpred_o;

  int n_chk = 0;
  int n_bad = 0;

  bfc_unit uut (.*);

  always #10 clk_i = ~clk_i; // 50 MHz

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_wide(int hi, int rd, int lo);
    return (32'(hi) << 16) | (32'(rd) << 12) | (32'(lo) << 7);
  endfunction

  function automatic logic [31:0] enc_split(int hi, int rd, int lo);
    return (32'(lo >> 2) << 12) | (32'(rd) << 8) | (32'(lo & 3) << 6) | 32'(hi);
  endfunction

  function automatic logic [31:0] clr(logic [31:0] v, int lo, int hi);
    logic [31:0] r = v;
    for (int b = lo; b <= hi; b++) r[b] = 1'b0;
    return r;
  endfunction

  // drive at negedge, sample at following negedge (one posedge between)
  task automatic op(input logic f, input logic [31:0] ins, input logic c, input logic [31:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; fmt_i = f; insn_i = ins; cond_pass_i = c; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic legal_op(input string tag, input logic f, input int hi, input int rd,
                          input int lo, input logic [31:0] s);
    op(f, f ? enc_split(hi, rd, lo) : enc_wide(hi, rd, lo), 1'b1, s);
    chk({tag, " result"}, result_o, clr(s, lo, hi));
    chk({tag, " rd"}, 32'(rd_o), 32'(rd));
    chk({tag, " wr_en"}, 32'(wr_en_o), 32'd1);
    chk({tag, " unpred"}, 32'(unpred_o), 32'd0);
    chk({tag, " valid"}, 32'(valid_o), 32'd1);
  endtask

  task automatic t_reset;
    chk("R8 valid_o in reset", 32'(valid_o), 0);
    chk("R8 wr_en_o in reset", 32'(wr_en_o), 0);
    chk("R8 unpred_o in reset", 32'(unpred_o), 0);
  endtask

  task automatic t_main;
    legal_op("R1 R2 mid", 1'b0, 11, 3, 4, 32'hFFFF_FFFF);
    legal_op("R1 R2 pattern", 1'b0, 27, 7, 16, 32'hA5C3_5A3C);
    legal_op("R1 R3 split lo=13", 1'b1, 20, 2, 13, 32'hDEAD_BEEF);
    legal_op("R3 split lo=30", 1'b1, 31, 9, 30, 32'h1234_5678 | 32'hC000_0000);
    legal_op("R3 split lo=3", 1'b1, 5, 14, 3, 32'hFFFF_FFFF);
  endtask

  task automatic t_bounds;
    legal_op("R10 full word", 1'b0, 31, 1, 0, 32'hFFFF_FFFF);
    legal_op("R10 single bit31", 1'b0, 31, 0, 31, 32'hFFFF_FFFF);
    legal_op("R10 single bit0 split", 1'b1, 0, 5, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_illegal;
    op(1'b0, enc_wide(3, 4, 9), 1'b1, 32'hFFFF_FFFF);
    chk("R4 unpred hi<lo", 32'(unpred_o), 1);
    chk("R4 wr_en hi<lo", 32'(wr_en_o), 0);
    op(1'b1, enc_split(10, 15, 2), 1'b1, 32'hFFFF_FFFF);
    chk("R5 unpred rd15", 32'(unpred_o), 1);
    chk("R5 wr_en rd15", 32'(wr_en_o), 0);
    op(1'b0, enc_wide(1, 15, 20), 1'b1, 32'h0);
    chk("R4 R5 both unpred", 32'(unpred_o), 1);
    chk("R4 R5 both wr_en", 32'(wr_en_o), 0);
  endtask

  task automatic t_cond;
    op(1'b0, enc_wide(8, 2, 0), 1'b0, 32'hFFFF_FFFF);
    chk("R6 no write", 32'(wr_en_o), 0);
    chk("R6 no flag", 32'(unpred_o), 0);
    op(1'b0, enc_wide(1, 15, 20), 1'b0, 32'h0);
    chk("R6 illegal cond-fail wr_en", 32'(wr_en_o), 0);
    chk("R6 illegal cond-fail unpred", 32'(unpred_o), 0);
  endtask

  task automatic t_pipe;
    @(negedge clk_i);
    valid_i = 1'b1; fmt_i = 1'b0; cond_pass_i = 1'b1;
    insn_i = enc_wide(2, 15, 0); src_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R7 b2b first unpred", 32'(unpred_o), 1);
    insn_i = enc_wide(15, 6, 8); src_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R7 b2b second result", result_o, 32'hFFFF_00FF);
    chk("R7 b2b second wr_en", 32'(wr_en_o), 1);
    chk("R7 R9 b2b second unpred", 32'(unpred_o), 0);
    chk("R7 b2b second rd", 32'(rd_o), 6);
    @(negedge clk_i);
    chk("R7 valid drops", 32'(valid_o), 0);
    chk("R9 wr_en idle", 32'(wr_en_o), 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_main();
    t_bounds();
    t_illegal();
    t_cond();
    t_pipe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule